// File: doc/BRIEF.md
# Serial Peripheral Slave Shifter with Pause

This block is the byte-level front end of a serial memory slave. It watches the chip-select, serial clock, pause and serial-in pins through a synchronizer clocked by the system clock. It takes in a bit on each rising serial clock edge and moves out a response bit on each falling edge. Every completed byte is handed to the command logic together with its position inside the current chip-select frame. The command logic answers by presenting the next response byte and an output-enable flag. The block does no command decoding and no memory access.

The pause input (`hold_n`) lets the master stop a transfer in the middle of a sequence. The pause starts or ends only while the serial clock is low. While paused, the output driver is off, serial-in is ignored and clock edges do not count. When the pause ends, the transfer continues from the bit where it stopped. The block works with either clock idle level, so SPI mode 0 and mode 3 are both supported. The serial output is given as a data bit plus an enable (`so_oe`), and the pad ring builds the tri-state buffer from them.

Top module: `spi_hold_slave`

## Requirements
- R1: Data is received MSB first. On the rising clock edge that handles the eighth sampled bit of a byte, `rx_valid` is high for exactly one `clk` cycle and `rx_byte` holds the assembled byte.
- R2: `rx_index` gives the zero-based position of the delivered byte within the current chip-select frame, counting modulo 2^IDX_W.
- R3: `tx_data` and `tx_en` are captured on the first falling serial clock edge of each byte slot, which is the first falling edge seen while the in-byte bit count is zero. After that, `so_dat` shows the captured byte MSB first and moves one bit on each later falling edge. `so_oe` is 1 only while the captured `tx_en` is 1. In mode 0 the first byte of a frame has no preceding falling edge, so `so_oe` stays 0 for it.
- R4: When the clock idles high (mode 3), the first falling edge after chip select goes low captures the response for byte 0. Reception and transmission are otherwise the same as in mode 0.
- R5: If `hold_n` is seen low while the serial clock is low, a pause begins. During the pause `so_oe` is 0, serial clock edges do not move the bit count and `si` has no effect.
- R6: If `hold_n` is seen high while the serial clock is low, the pause ends. Reception and transmission then continue with the next bit, so the bytes received and sent are the same as for a transfer with no pause.
- R7: A change of `hold_n` seen while the serial clock is high takes effect only in the next low phase. The falling edge that ends that high phase is still handled normally.
- R8: While `cs_n` is high, the bit and byte counts are cleared, any pause is cancelled and `so_oe` is 0. The next frame's first byte has index 0.
- R9: While in reset and just after it, `rx_valid` and `so_oe` are 0.
- R10: A pin change takes effect at the `clk` edge that samples it through SYNC_STAGES synchronizer flops. Outputs change at the `clk` edge that follows that sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin, either idle level |
| hold_n | input | 1 | Pause pin, active low |
| si | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle strobe: a byte has been received |
| rx_byte | output | 8 | Received byte |
| rx_index | output | IDX_W | Position of the byte within the frame |
| tx_data | input | 8 | Response byte for the coming byte slot |
| tx_en | input | 1 | Drive the serial output during the coming byte slot |
| so_dat | output | 1 | Serial output data bit |
| so_oe | output | 1 | Serial output enable; 0 means high impedance |

## Verification
The bound checker tests several properties on every cycle. It checks that the receive strobe is a single pulse that falls on a byte boundary and that the byte counter stays one ahead of the reported index. It checks that the bit count is frozen during a pause, that a pause starts or ends only after a low serial clock sample, and that chip-select high clears every count, the pause and the output enable. Whether the bytes are assembled correctly and the response comes out MSB first, in both clock idle levels, can only be shown by the bench's scenarios. The same holds for a transfer split by a pause, whether the pause was asked for in the low phase or deferred from the high phase, and for a frame cut off while paused.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  bitcnt_t;

  // true when the count marks the final bit of a byte
  function automatic logic is_last_bit(bitcnt_t c);
    return c == bitcnt_t'(BYTE_W - 1);
  endfunction

  // MSB-first accumulation of a new serial bit
  function automatic byte_t shift_in(byte_t acc, logic b);
    return {acc[BYTE_W-2:0], b};
  endfunction

  // advance the response register by one bit
  function automatic byte_t shift_out(byte_t sh);
    return {sh[BYTE_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_hold.sv
module spi_edge_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  output logic rise_ev,
  output logic fall_ev,
  output logic held
);
  logic sck_q;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck_s;               // keeps tracking during a pause
      if (cs_s)        held <= 1'b0;
      else if (!sck_s) held <= !hold_s;  // pause changes only in low phase
    end
  end

  assign active  = !cs_s && !held;
  assign rise_ev = active && sck_s && !sck_q;
  assign fall_ev = active && !sck_s && sck_q;
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path
  import spi_hold_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             rise_ev,
  input  logic             si_s,
  output logic             rx_valid,
  output byte_t            rx_byte,
  output logic [IDX_W-1:0] rx_index,
  output bitcnt_t          bit_cnt,
  output logic [IDX_W-1:0] byte_cnt
);
  byte_t acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_index <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (rise_ev) begin
        acc <= shift_in(acc, si_s);
        if (is_last_bit(bit_cnt)) begin
          rx_valid <= 1'b1;
          rx_byte  <= shift_in(acc, si_s);
          rx_index <= byte_cnt;
          byte_cnt <= byte_cnt + 1'b1;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_hold_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_s,
  input  logic    fall_ev,
  input  bitcnt_t bit_cnt,
  input  byte_t   tx_data,
  input  logic    tx_en,
  output logic    so_bit,
  output logic    oe_byte
);
  byte_t tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      oe_byte <= 1'b0;
    end else if (cs_s) begin
      tx_sh   <= '0;
      oe_byte <= 1'b0;
    end else if (fall_ev) begin
      if (bit_cnt == '0) begin
        tx_sh   <= tx_data;
        oe_byte <= tx_en;
      end else begin
        tx_sh <= shift_out(tx_sh);
      end
    end
  end

  assign so_bit = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            sck,
  input  logic                            hold_n,
  input  logic                            si,
  output logic                            rx_valid,
  output logic [spi_hold_pkg::BYTE_W-1:0] rx_byte,
  output logic [IDX_W-1:0]                rx_index,
  input  logic [spi_hold_pkg::BYTE_W-1:0] tx_data,
  input  logic                            tx_en,
  output logic                            so_dat,
  output logic                            so_oe
);
  import spi_hold_pkg::*;

  localparam int         NPIN    = 4;
  // pin order {cs_n, sck, hold_n, si}; idle values after reset
  localparam logic [NPIN-1:0] PIN_RST = 4'b1010;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic cs_s, sck_s, hold_s, si_s;
  logic rise_ev, fall_ev, held;
  bitcnt_t bit_cnt;
  logic [IDX_W-1:0] byte_cnt;
  logic oe_byte;

  assign pin_raw = {cs_n, sck, hold_n, si};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g])
    );
  end

  assign {cs_s, sck_s, hold_s, si_s} = pin_s;

  spi_edge_hold u_edge (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .held(held)
  );

  spi_rx_path #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise_ev(rise_ev), .si_s(si_s),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_index(rx_index),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt)
  );

  spi_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_ev(fall_ev), .bit_cnt(bit_cnt),
    .tx_data(tx_data), .tx_en(tx_en), .so_bit(so_dat), .oe_byte(oe_byte)
  );

  assign so_oe = oe_byte && !held;
endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             sck_s,
  input logic             held,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [IDX_W-1:0] byte_cnt,
  input logic             rx_valid,
  input logic [IDX_W-1:0] rx_index,
  input logic             so_oe
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R1
  AST_VALID_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> bit_cnt == '0); // R1
  AST_INDEX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> byte_cnt == IDX_W'(rx_index + 1'b1)); // R2
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    held && !cs_s |=> bit_cnt == $past(bit_cnt)); // R5
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s)); // R7
  AST_PAUSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> !$past(sck_s) || $past(cs_s)); // R6
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> bit_cnt == '0 && byte_cnt == '0 && !held && !so_oe); // R8
endmodule

bind spi_hold_slave spi_hold_slave_chk #(.IDX_W(IDX_W), .CNT_W(spi_hold_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .held(held),
  .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .rx_valid(rx_valid),
  .rx_index(rx_index), .so_oe(so_oe)
);

// File: tb/sim_spi_hold_slave.sv
module sim_spi_hold_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int IDX_W      = 8;
  localparam int HP         = 8;   // clk cycles per serial clock half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_en = 1'b0;
  logic rx_valid, so_dat, so_oe;
  logic [7:0] rx_byte;
  logic [IDX_W-1:0] rx_index;

  int checks = 0, errors = 0;
  logic [7:0] rd;
  bit oe_seen;
  int got_b[$], got_i[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_slave #(.SYNC_STAGES(SYNC), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n), .si(si),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_index(rx_index),
    .tx_data(tx_data), .tx_en(tx_en), .so_dat(so_dat), .so_oe(so_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] pin_q[$] = '{4'b1010, 4'b1010};
  logic [3:0] pd;
  int m_bits, m_bytes, m_acc, m_pos, m_rx, m_idx;
  bit m_held, m_prev, m_valid, m_oe;
  logic [7:0] m_tx;

  always @(posedge clk) begin
    pin_q.push_back({cs_n, sck, hold_n, si});
    pd = pin_q.pop_front();          // pin value SYNC edges ago
    m_valid = 1'b0;
    if (!rst_n) begin
      m_bits = 0; m_bytes = 0; m_acc = 0; m_held = 0; m_prev = 0;
      m_oe = 0; m_tx = 0; m_pos = 7;
    end else begin
      if (pd[3]) begin
        m_bits = 0; m_bytes = 0; m_held = 0; m_oe = 0; m_tx = 0; m_pos = 7;
      end else begin
        if (!m_held && pd[2] && !m_prev) begin
          m_acc = ((m_acc << 1) | pd[0]) & 255;
          m_bits++;
          if (m_bits == 8) begin
            m_valid = 1'b1; m_rx = m_acc; m_idx = m_bytes % (1 << IDX_W);
            m_bytes++; m_bits = 0;
          end
        end
        if (!m_held && !pd[2] && m_prev) begin
          if (m_bits == 0) begin m_tx = tx_data; m_oe = tx_en; m_pos = 7; end
          else if (m_pos > 0) m_pos--;
        end
        if (!pd[2]) m_held = !pd[1];
      end
      m_prev = pd[2];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 R10 rx_valid", rx_valid, m_valid);
      if (m_valid) begin
        check("R1 rx_byte", rx_byte, m_rx);
        check("R2 rx_index", rx_index, m_idx);
      end
      check("R3 R5 so_oe", so_oe, m_oe && !m_held);
      if (so_oe && m_oe && !m_held) check("R3 so_dat", so_dat, m_tx[m_pos]);
      if (rx_valid) begin got_b.push_back(rx_byte); got_i.push_back(rx_index); end
    end
  end

  // ---------------- pin-level stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample_so();
    rd = {rd[6:0], so_oe & so_dat};
    oe_seen |= so_oe;
  endtask

  task automatic pulse_bit(input bit v, input bit m3);
    if (m3) begin
      sck = 1'b0; si = v; wait_clk(HP); sample_so(); sck = 1'b1; wait_clk(HP);
    end else begin
      si = v; wait_clk(HP); sample_so(); sck = 1'b1; wait_clk(HP); sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit m3);
    rd = 8'h00; oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) pulse_bit(b[i], m3);
  endtask

  task automatic frame_start();
    cs_n = 1'b0; wait_clk(HP);
  endtask

  task automatic frame_end();
    wait_clk(HP); cs_n = 1'b1; wait_clk(4*HP);
  endtask

  task automatic expect_rx(input string tag, input int b, input int idx);
    if (got_b.size() == 0) begin
      check(tag, -1, b);
    end else begin
      check(tag, got_b.pop_front(), b);
      check(tag, got_i.pop_front(), idx);
    end
  endtask

  initial begin
    wait_clk(3);
    check("R9 rx_valid in reset", rx_valid, 0);
    check("R9 so_oe in reset", so_oe, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R9 rx_valid after reset", rx_valid, 0);
    check("R9 so_oe after reset", so_oe, 0);

    // Frame A: mode 0, three bytes, constant response
    tx_data = 8'hC3; tx_en = 1'b1;
    frame_start();
    send_byte(8'hA5, 1'b0);
    check("R3 mode0 first byte silent", oe_seen, 0);
    send_byte(8'h3C, 1'b0);
    check("R3 response byte1", rd, 8'hC3);
    send_byte(8'h81, 1'b0);
    check("R3 response byte2", rd, 8'hC3);
    frame_end();
    expect_rx("R1 R2 frameA b0", 8'hA5, 0);
    expect_rx("R1 R2 frameA b1", 8'h3C, 1);
    expect_rx("R1 R2 frameA b2", 8'h81, 2);

    // Frame B: mode 3 (clock idles high)
    sck = 1'b1; wait_clk(4*HP);
    tx_data = 8'h96;
    frame_start();
    send_byte(8'h5A, 1'b1);
    check("R4 mode3 response byte0", rd, 8'h96);
    send_byte(8'hF0, 1'b1);
    check("R4 mode3 response byte1", rd, 8'h96);
    frame_end();
    expect_rx("R4 frameB b0", 8'h5A, 0);
    expect_rx("R4 frameB b1", 8'hF0, 1);
    sck = 1'b0; wait_clk(4*HP);

    // Frame C: pause requested while clock low
    tx_data = 8'h5E;
    frame_start();
    send_byte(8'h12, 1'b0);
    rd = 8'h00;
    for (int i = 7; i >= 5; i--) pulse_bit(8'h6B >> i, 1'b0);
    hold_n = 1'b0; wait_clk(HP);
    check("R5 output off in pause", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
    end
    check("R5 output still off", so_oe, 0);
    hold_n = 1'b1; wait_clk(HP);
    check("R6 output back after pause", so_oe, 1);
    for (int i = 4; i >= 0; i--) pulse_bit(8'h6B >> i, 1'b0);
    check("R6 response continues", rd, 8'h5E);
    frame_end();
    expect_rx("R5 frameC b0", 8'h12, 0);
    expect_rx("R6 frameC b1 across pause", 8'h6B, 1);

    // Frame D: pause requested while clock high is deferred
    tx_data = 8'hA1;
    frame_start();
    send_byte(8'h00, 1'b0);
    rd = 8'h00;
    for (int i = 7; i >= 6; i--) pulse_bit(8'hC7 >> i, 1'b0);
    si = 1'b0; wait_clk(HP); sample_so(); sck = 1'b1; wait_clk(2);
    hold_n = 1'b0; wait_clk(HP);
    check("R7 pause deferred in high phase", so_oe, 1);
    sck = 1'b0; wait_clk(HP);
    check("R7 pause active in low phase", so_oe, 0);
    for (int k = 0; k < 2; k++) begin
      si = ~si; sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
    end
    hold_n = 1'b1; wait_clk(HP);
    for (int i = 4; i >= 0; i--) pulse_bit(8'hC7 >> i, 1'b0);
    check("R7 response intact", rd, 8'hA1);
    frame_end();
    expect_rx("R7 frameD b0", 8'h00, 0);
    expect_rx("R7 frameD b1", 8'hC7, 1);

    // Frame E: chip select raised during a pause
    tx_data = 8'hFF;
    frame_start();
    send_byte(8'h77, 1'b0);
    for (int i = 0; i < 3; i++) pulse_bit(1'b1, 1'b0);
    hold_n = 1'b0; wait_clk(HP);
    cs_n = 1'b1; wait_clk(2*HP);
    check("R8 output off after deselect", so_oe, 0);
    hold_n = 1'b1; wait_clk(2*HP);
    frame_start();
    send_byte(8'h11, 1'b0);
    check("R8 new frame byte0 silent", oe_seen, 0);
    frame_end();
    expect_rx("R8 frameE b0", 8'h77, 0);
    expect_rx("R8 new frame index restart", 8'h11, 0);
    check("R8 no stray byte", got_b.size(), 0);

    // Frame F: response disabled
    tx_en = 1'b0;
    frame_start();
    send_byte(8'h06, 1'b0);
    send_byte(8'h04, 1'b0);
    check("R3 disabled response stays off", oe_seen, 0);
    frame_end();
    expect_rx("R3 frameF b0", 8'h06, 0);
    expect_rx("R3 frameF b1", 8'h04, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule